// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits behind a PHY and watches its nibble-wide receive stream: four data bits, a data-valid strobe and a receive-error strobe, one nibble per clock. It hunts for the preamble and the start-of-frame delimiter. From then on it puts nibble pairs together into bytes, low nibble first. Each byte goes to three places: a CRC-32 engine, a header parser and a forwarding path.

The parser sorts the destination address into broadcast, multicast or unicast. It counts up to two VLAN tags and reads the final type/length field. It also recognises MAC control frames and checks their opcode. The forwarding path can pass every byte through unchanged. It can instead hold back four bytes so that the FCS is never forwarded, and it drops any zero padding beyond the length that a length field declares.

When the data-valid strobe falls, the block issues a one-cycle status pulse with a 32-bit word. The word carries the byte count, the error flags, the destination class, the tag count and one summary filter bit. A broadcast-disable input forces that filter bit to zero for broadcast frames.

Top module: `eth_rx_checker`

## Requirements
- R1: A frame begins only after a 0x5 nibble directly followed by a 0xD nibble while `rx_dv` is high; each later pair of valid nibbles forms one byte, low nibble first. A valid burst with no such start yields no status pulse and no forwarded byte.
- R2: `stat_word[23:22]` gives the destination class: 2 when the first six bytes are all 0xFF, otherwise 1 when bit 0 of the first byte is 1, otherwise 0.
- R3: `stat_word[16]` is set when the frame fails the FCS check. The check uses the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones). The FCS is sent complemented, least significant byte first, so a good frame leaves residue 0xC704DD7B (0xDEBB20E3 in shift-right bit order).
- R4: A type field of 0x8100 or 0x88A8 at byte 12, and again at byte 16, counts as a VLAN tag, up to two. `stat_word[25:24]` holds the tag count. `stat_word[18]` is set when the byte count exceeds 1518 + 4 × tags.
- R5: `stat_word[15:0]` is the number of whole bytes after the delimiter, FCS included. `stat_word[17]` (runt) is set when that count is below 64.
- R6: `stat_word[19]` is set when the frame ends after an odd number of nibbles. The stray nibble is not part of the count or the FCS check.
- R7: `stat_word[20]` is set when `rx_er` is high in any valid nibble cycle of the frame after the delimiter.
- R8: `stat_word[21]` is set when the final type field is 0x8808 and the two bytes after it are not 0x0001.
- R9: `stat_word[30]` is the OR of bits 21..16. It is forced to 0 for a frame of class 2 while `cfg_bcast_off` is 1. All bits not named in R2..R9 read 0.
- R10: With `cfg_strip` at 0, every frame byte is forwarded in order, FCS included. With it at 1, the last four bytes are withheld. In addition, when the final type field holds a value of 1500 or less, only bytes with index below (field offset + 2 + value) are forwarded.
- R11: After reset `stat_valid` and `fwd_valid` are 0 and `stat_word` is 0. `stat_valid` pulses for one cycle per frame, two clocks after the first low `rx_dv` sample. `stat_word` keeps its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | PHY-reported receive error |
| cfg_strip | input | 1 | Withhold FCS and padding from the forwarded bytes |
| cfg_bcast_off | input | 1 | Force the filter bit to 0 for broadcast frames |
| fwd_data | output | 8 | Forwarded frame byte |
| fwd_valid | output | 1 | Qualifies `fwd_data` |
| stat_valid | output | 1 | One-cycle end-of-frame pulse |
| stat_word | output | 32 | End-of-frame status word |

## Verification
The hardest situation to reach from the ports is a stacked frame at the length limit. It needs two tags, a length-field payload or a control opcode placed behind the shifted type offset, and a byte count within one of 1526. Random frames alone rarely land there. The bench therefore builds frames byte by byte from a descriptor (destination kind, tag count, type value, payload size) and appends a computed FCS. Directed frames sit at 63/64, 1518/1519 and 1526/1527 bytes. Seeded random frames mix padding stripping, corrupted payloads, stray nibbles and error strobes on top of that.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 16;
    localparam int FCS_BYTES  = 4;
    localparam int TAG_BYTES  = 4;
    localparam int MAX_TAGS   = 2;
    localparam int TAG_CNT_W  = $clog2(MAX_TAGS + 1);
    localparam int ADDR_BYTES = 6;
    localparam int TYPE_OFS   = 12;
    localparam int MIN_FRAME  = 64;
    localparam int MAX_FRAME  = 1518;
    localparam int MAX_LENFLD = 1500;

    localparam logic [NIB_W-1:0]  PRE_NIB   = 4'h5;
    localparam logic [NIB_W-1:0]  SFD_NIB   = 4'hD;
    localparam logic [15:0]       TPID_C    = 16'h8100;
    localparam logic [15:0]       TPID_S    = 16'h88A8;
    localparam logic [15:0]       CTRL_TYPE = 16'h8808;
    localparam logic [15:0]       PAUSE_OP  = 16'h0001;

    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD   = 32'hDEBB20E3;

    // status word bit positions
    localparam int SB_CRC  = 16;
    localparam int SB_RUNT = 17;
    localparam int SB_LONG = 18;
    localparam int SB_DRIB = 19;
    localparam int SB_PHY  = 20;
    localparam int SB_CTRL = 21;
    localparam int SB_CLS  = 22;
    localparam int SB_TAGS = 24;
    localparam int SB_FILT = 30;

    typedef enum logic [1:0] {
        DST_UNI   = 2'd0,
        DST_MULTI = 2'd1,
        DST_BCAST = 2'd2
    } dst_class_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [BYTE_W-1:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_rx_sync.sv
module eth_rx_sync
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rx_dv,
    input  logic              rx_er,
    output logic              byte_v,
    output logic [BYTE_W-1:0] byte_d,
    output logic              fend,
    output logic              odd,
    output logic              phy_err
);

    typedef enum logic {S_HUNT, S_DATA} sync_st_e;

    typedef struct packed {
        sync_st_e          st;
        logic              saw_pre;
        logic              half;
        logic [NIB_W-1:0]  lo;
        logic              bv;
        logic [BYTE_W-1:0] b;
        logic              fe;
        logic              odd;
        logic              er;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.bv = 1'b0;
        d.fe = 1'b0;
        unique case (q.st)
            S_HUNT: begin
                if (rx_dv) begin
                    if (rxd == SFD_NIB && q.saw_pre) begin
                        d.st      = S_DATA;
                        d.half    = 1'b0;
                        d.er      = 1'b0;
                        d.odd     = 1'b0;
                        d.saw_pre = 1'b0;
                    end else begin
                        d.saw_pre = (rxd == PRE_NIB);
                    end
                end else begin
                    d.saw_pre = 1'b0;
                end
            end
            S_DATA: begin
                if (rx_dv) begin
                    if (rx_er) d.er = 1'b1;
                    if (!q.half) begin
                        d.lo   = rxd;
                        d.half = 1'b1;
                    end else begin
                        d.b    = {rxd, q.lo};
                        d.bv   = 1'b1;
                        d.half = 1'b0;
                    end
                end else begin
                    d.fe      = 1'b1;
                    d.odd     = q.half;
                    d.half    = 1'b0;
                    d.st      = S_HUNT;
                    d.saw_pre = 1'b0;
                end
            end
            default: d.st = S_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_v  = q.bv;
    assign byte_d  = q.b;
    assign fend    = q.fe;
    assign odd     = q.odd;
    assign phy_err = q.er;

    // a byte and the end of its frame never coincide
    assert_byte_end_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.bv && q.fe));

endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_v,
    input  logic [BYTE_W-1:0] byte_d,
    input  logic              clear,
    output logic              crc_ok
);

    typedef struct packed {
        logic [31:0] crc;
    } crc_t;

    crc_t q, d;

    always_comb begin
        d = q;
        if (clear)       d.crc = CRC_INIT;
        else if (byte_v) d.crc = crc_step(q.crc, byte_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.crc <= CRC_INIT;
        else        q <= d;
    end

    assign crc_ok = (q.crc == CRC_GOOD);

    // the register is preset between frames (R3)
    assert_crc_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q.crc == CRC_INIT));

endmodule

// File: rtl/eth_rx_fwd.sv
module eth_rx_fwd
    import eth_rx_pkg::*;
#(
    parameter int HOLD = FCS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [BYTE_W-1:0] in_d,
    input  logic              fend,
    input  logic              strip,
    input  logic              lim_v,
    input  logic [IDX_W-1:0]  lim,
    output logic              out_v,
    output logic [BYTE_W-1:0] out_d
);

    localparam int CNT_W = $clog2(HOLD + 1);

    typedef struct packed {
        logic [HOLD-1:0][BYTE_W-1:0] line;
        logic [CNT_W-1:0]            cnt;
        logic [IDX_W-1:0]            oidx;
        logic                        ov;
        logic [BYTE_W-1:0]           od;
    } fwd_t;

    fwd_t q, d;

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        if (in_v) begin
            if (!strip) begin
                d.ov = 1'b1;
                d.od = in_d;
            end else begin
                d.line[0] = in_d;
                for (int i = 1; i < HOLD; i++) d.line[i] = q.line[i-1];
                if (q.cnt == CNT_W'(HOLD)) begin
                    d.od = q.line[HOLD-1];
                    d.ov = !(lim_v && (q.oidx >= lim));
                    if (q.oidx != '1) d.oidx = q.oidx + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
        if (fend) begin
            d.cnt  = '0;
            d.oidx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_v = q.ov;
    assign out_d = q.od;

    // output bytes follow an input byte by exactly one cycle (R10)
    assert_fwd_follows_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.ov |-> $past(in_v));

endmodule

// File: rtl/eth_rx_checker.sv
module eth_rx_checker
    import eth_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  rxd,
    input  logic        rx_dv,
    input  logic        rx_er,
    input  logic        cfg_strip,
    input  logic        cfg_bcast_off,
    output logic [7:0]  fwd_data,
    output logic        fwd_valid,
    output logic        stat_valid,
    output logic [31:0] stat_word
);

    logic              bv, fe, odd, perr, crc_ok;
    logic [BYTE_W-1:0] bb;

    typedef struct packed {
        logic [IDX_W-1:0]     idx;
        logic [TAG_CNT_W-1:0] tags;
        logic [BYTE_W-1:0]    hi;
        logic                 fin;
        logic                 ctl;
        logic                 ctl_bad;
        logic                 lim_v;
        logic [IDX_W-1:0]     lim;
        logic                 bc_all;
        logic                 mc;
        logic                 sv;
        logic [31:0]          sw;
    } chk_t;

    chk_t q, d;

    logic [IDX_W-1:0] tpos, max_len;
    logic [15:0]      fld;
    dst_class_e       cls;
    logic [5:0]       errs;

    eth_rx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .byte_v(bv), .byte_d(bb), .fend(fe), .odd(odd), .phy_err(perr)
    );

    eth_rx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .byte_v(bv), .byte_d(bb), .clear(fe), .crc_ok(crc_ok)
    );

    eth_rx_fwd #(.HOLD(FCS_BYTES)) u_fwd (
        .clk(clk), .rst_n(rst_n), .in_v(bv), .in_d(bb), .fend(fe), .strip(cfg_strip),
        .lim_v(q.lim_v), .lim(q.lim), .out_v(fwd_valid), .out_d(fwd_data)
    );

    always_comb begin
        d       = q;
        d.sv    = 1'b0;
        tpos    = IDX_W'(TYPE_OFS) + IDX_W'(TAG_BYTES) * IDX_W'(q.tags);
        max_len = IDX_W'(MAX_FRAME) + IDX_W'(TAG_BYTES) * IDX_W'(q.tags);
        fld     = {q.hi, bb};
        cls     = DST_UNI;
        errs    = '0;
        if (bv) begin
            if (q.idx != '1) d.idx = q.idx + 1'b1;
            if (q.idx < IDX_W'(ADDR_BYTES) && bb != 8'hFF) d.bc_all = 1'b0;
            if (q.idx == '0) d.mc = bb[0];
            if (!q.fin) begin
                if (q.idx == tpos) begin
                    d.hi = bb;
                end else if (q.idx == tpos + 1'b1) begin
                    if ((fld == TPID_C || fld == TPID_S) && q.tags < TAG_CNT_W'(MAX_TAGS)) begin
                        d.tags = q.tags + 1'b1;
                    end else begin
                        d.fin = 1'b1;
                        if (fld <= 16'(MAX_LENFLD)) begin
                            d.lim_v = 1'b1;
                            d.lim   = tpos + IDX_W'(2) + IDX_W'(fld);
                        end
                        if (fld == CTRL_TYPE) d.ctl = 1'b1;
                    end
                end
            end else if (q.ctl) begin
                if (q.idx == tpos + IDX_W'(2))
                    d.hi = bb;
                else if (q.idx == tpos + IDX_W'(3) && fld != PAUSE_OP)
                    d.ctl_bad = 1'b1;
            end
        end
        if (fe) begin
            if (q.bc_all && q.idx >= IDX_W'(ADDR_BYTES)) cls = DST_BCAST;
            else if (q.mc)                               cls = DST_MULTI;
            errs = {q.ctl_bad, perr, odd, (q.idx > max_len),
                    (q.idx < IDX_W'(MIN_FRAME)), !crc_ok};
            d.sv = 1'b1;
            d.sw = '0;
            d.sw[15:0]                 = 16'(q.idx);
            d.sw[SB_CTRL:SB_CRC]       = errs;
            d.sw[SB_CLS+1:SB_CLS]      = cls;
            d.sw[SB_TAGS+1:SB_TAGS]    = 2'(q.tags);
            d.sw[SB_FILT]              = (|errs) && !(cfg_bcast_off && cls == DST_BCAST);
            d.idx     = '0;
            d.tags    = '0;
            d.hi      = '0;
            d.fin     = 1'b0;
            d.ctl     = 1'b0;
            d.ctl_bad = 1'b0;
            d.lim_v   = 1'b0;
            d.lim     = '0;
            d.bc_all  = 1'b1;
            d.mc      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.bc_all <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign stat_valid = q.sv;
    assign stat_word  = q.sw;

    assert_tag_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.tags <= TAG_CNT_W'(MAX_TAGS));

    assert_stat_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.sv |=> !q.sv);

    assert_filter_needs_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sv && q.sw[SB_FILT]) |-> (|q.sw[SB_CTRL:SB_CRC]));

endmodule

// File: tb/test_eth_rx_checker.sv
module test_eth_rx_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rxd;
    logic        rx_dv, rx_er, cfg_strip, cfg_bcast_off;
    logic [7:0]  fwd_data;
    logic        fwd_valid, stat_valid;
    logic [31:0] stat_word;

    always #5 clk = ~clk;

    eth_rx_checker i_eth_rx_checker (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .cfg_strip(cfg_strip), .cfg_bcast_off(cfg_bcast_off),
        .fwd_data(fwd_data), .fwd_valid(fwd_valid),
        .stat_valid(stat_valid), .stat_word(stat_word)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  fr  [0:2047];
    logic [7:0]  got [0:2047];
    int          fn, gn, svn;
    logic [31:0] got_w;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [3:0] n, input logic dv, input logic er);
        @(negedge clk);
        if (fwd_valid && gn < 2048) begin got[gn] = fwd_data; gn++; end
        if (stat_valid) begin got_w = stat_word; svn++; end
        rxd = n; rx_dv = dv; rx_er = er;
    endtask

    function automatic logic [31:0] fcs_of(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                c = ((c[0] ^ fr[i][k]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return ~c;
    endfunction

    task automatic build(input int kind, input int tags, input logic [15:0] tval,
                         input int plen, input logic [15:0] op, input bit corrupt);
        int p = 0;
        for (int i = 0; i < 6; i++) begin
            case (kind)
                0: fr[p] = (i == 0) ? 8'h02 : 8'(i);
                1: fr[p] = (i == 0) ? 8'h01 : 8'h5E + 8'(i);
                default: fr[p] = 8'hFF;
            endcase
            p++;
        end
        for (int i = 0; i < 6; i++) begin fr[p] = 8'h10 + 8'(i); p++; end
        for (int t = 0; t < tags; t++) begin
            fr[p] = (t == 0 && tags == 2) ? 8'h88 : 8'h81;
            fr[p+1] = (t == 0 && tags == 2) ? 8'hA8 : 8'h00;
            fr[p+2] = 8'h00; fr[p+3] = 8'(t + 3); p += 4;
        end
        fr[p] = tval[15:8]; fr[p+1] = tval[7:0]; p += 2;
        for (int i = 0; i < plen; i++) begin
            if (tval == 16'h8808 && i == 0)      fr[p] = op[15:8];
            else if (tval == 16'h8808 && i == 1) fr[p] = op[7:0];
            else if (tval <= 16'd1500 && i >= int'(tval)) fr[p] = 8'h00;
            else fr[p] = 8'($urandom_range(0, 255));
            p++;
        end
        begin
            logic [31:0] f = fcs_of(p);
            fr[p] = f[7:0]; fr[p+1] = f[15:8]; fr[p+2] = f[23:16]; fr[p+3] = f[31:24];
        end
        fn = p + 4;
        if (corrupt) fr[14] = fr[14] ^ 8'h40;
    endtask

    task automatic send(input int n, input bit drib, input int er_pos, input int junk);
        gn = 0; svn = 0;
        for (int i = 0; i < junk; i++) tick(4'h3, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++) tick(4'h5, 1'b1, 1'b0);
        tick(4'hD, 1'b1, 1'b0);
        for (int i = 0; i < n; i++) begin
            tick(fr[i][3:0], 1'b1, 1'b0 | (er_pos == 2*i));
            tick(fr[i][7:4], 1'b1, 1'b0 | (er_pos == 2*i+1));
        end
        if (drib) tick(4'hA, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) tick(4'h0, 1'b0, 1'b0);
    endtask

    task automatic analyze(input int n, output int cls, output int tg, output bit cbad,
                           output bit lenf, output int lim);
        int pos = 12;
        logic [15:0] t;
        tg = 0; cbad = 0; lenf = 0; lim = 0;
        if (n >= 6 && fr[0] == 8'hFF && fr[1] == 8'hFF && fr[2] == 8'hFF &&
            fr[3] == 8'hFF && fr[4] == 8'hFF && fr[5] == 8'hFF) cls = 2;
        else if (n >= 1 && fr[0][0]) cls = 1;
        else cls = 0;
        while (pos + 1 < n) begin
            t = {fr[pos], fr[pos+1]};
            if ((t == 16'h8100 || t == 16'h88A8) && tg < 2) begin tg++; pos += 4; end
            else begin
                if (t <= 16'd1500) begin lenf = 1; lim = pos + 2 + int'(t); end
                if (t == 16'h8808 && pos + 3 < n && {fr[pos+2], fr[pos+3]} != 16'h0001) cbad = 1;
                break;
            end
        end
    endtask

    task automatic run(input string tag, input int n, input bit drib, input bit er,
                       input bit strip, input bit boff, input int junk);
        int cls, tg, lim, keep;
        bit cbad, lenf, fok;
        logic [31:0] w;
        bit same;
        cfg_strip = strip; cfg_bcast_off = boff;
        send(n, drib, er ? 7 : -1, junk);
        analyze(n, cls, tg, cbad, lenf, lim);
        fok = (n >= 4) && (fcs_of(n - 4) == {fr[n-1], fr[n-2], fr[n-3], fr[n-4]});
        w = '0;
        w[15:0] = 16'(n);
        w[16] = !fok;
        w[17] = n < 64;
        w[18] = n > 1518 + 4 * tg;
        w[19] = drib;
        w[20] = er;
        w[21] = cbad;
        w[23:22] = 2'(cls);
        w[25:24] = 2'(tg);
        w[30] = (|w[21:16]) && !(boff && cls == 2);
        check(svn == 1, {tag, " R11 one status pulse"}, 32'(svn), 32'd1);
        check(got_w == w, {tag, " R2 R3 R4 R5 R6 R7 R8 R9 status word"}, got_w, w);
        if (!strip) keep = n;
        else begin
            keep = (n > 4) ? n - 4 : 0;
            if (lenf && lim < keep) keep = lim;
        end
        check(gn == keep, {tag, " R10 forwarded count"}, 32'(gn), 32'(keep));
        same = 1;
        for (int i = 0; i < keep && i < gn; i++) if (got[i] != fr[i]) same = 0;
        check(same, {tag, " R10 forwarded bytes"}, 32'(same), 32'd1);
    endtask

    initial begin
        #(1_900_000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; rxd = 0; rx_dv = 0; rx_er = 0; cfg_strip = 0; cfg_bcast_off = 0;
        gn = 0; svn = 0; got_w = 0;
        repeat (4) @(negedge clk);
        check(stat_valid == 0 && fwd_valid == 0 && stat_word == 0, "R11 reset state",
              {stat_valid, fwd_valid, stat_word[29:0]}, 32'd0);
        rst_n = 1;

        // R1: valid burst with preamble only, no delimiter
        gn = 0; svn = 0;
        for (int i = 0; i < 20; i++) tick(4'h5, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) tick(4'h0, 1'b0, 1'b0);
        check(svn == 0 && gn == 0, "R1 no delimiter no status", 32'(svn + gn), 32'd0);

        build(0, 0, 16'h0800, 46, 0, 0); run("min64 R5", fn, 0, 0, 0, 0, 0);
        build(0, 0, 16'h0800, 45, 0, 0); run("runt63 R5", fn, 0, 0, 0, 0, 0);
        build(1, 0, 16'h0800, 50, 0, 0); run("junk R1", fn, 0, 0, 0, 0, 5);
        build(0, 0, 16'h0800, 1500, 0, 0); run("max1518 R4", fn, 0, 0, 0, 0, 0);
        build(0, 0, 16'h0800, 1501, 0, 0); run("long1519 R4", fn, 0, 0, 0, 0, 0);
        build(1, 1, 16'h0800, 1500, 0, 0); run("tag1522 R4", fn, 0, 0, 1, 0, 0);
        build(0, 2, 16'h0800, 1500, 0, 0); run("tag1526 R4", fn, 0, 0, 0, 0, 0);
        build(0, 2, 16'h0800, 1501, 0, 0); run("tag1527 R4", fn, 0, 0, 0, 0, 0);
        build(0, 0, 16'h0800, 60, 0, 0); run("dribble R6", fn, 1, 0, 0, 0, 0);
        build(0, 0, 16'h0800, 60, 0, 0); run("phyerr R7", fn, 0, 1, 0, 0, 0);
        build(0, 0, 16'h8808, 46, 16'h0001, 0); run("pause R8", fn, 0, 0, 0, 0, 0);
        build(0, 1, 16'h8808, 46, 16'h0002, 0); run("ctlbad R8", fn, 0, 0, 0, 0, 0);
        build(0, 0, 16'h0800, 60, 0, 1); run("crcbad R3", fn, 0, 0, 0, 0, 0);
        build(2, 0, 16'h0800, 60, 0, 1); run("bcast off R9", fn, 0, 0, 0, 1, 0);
        build(2, 0, 16'h0800, 60, 0, 1); run("bcast on R9", fn, 0, 0, 0, 0, 0);
        build(0, 0, 16'd10, 46, 0, 0); run("pad strip R10", fn, 0, 0, 1, 0, 0);
        build(1, 2, 16'd20, 46, 0, 0); run("pad strip tag R10", fn, 0, 0, 1, 0, 0);

        for (int r = 0; r < 30; r++) begin
            int kind = $urandom_range(0, 2);
            int tg   = $urandom_range(0, 2);
            int sel  = $urandom_range(0, 2);
            int plen = $urandom_range(30, 140);
            logic [15:0] tv;
            tv = (sel == 0) ? 16'h0800 : (sel == 1) ? 16'($urandom_range(0, plen)) : 16'h8808;
            build(kind, tg, tv, plen, ($urandom_range(0, 1) != 0) ? 16'h0001 : 16'h0003,
                  $urandom_range(0, 3) == 0);
            run("random", fn, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule